// File: doc/BRIEF.md
# Configuration-over-PCIe Programming Sequencer

This block is a hardware state machine that walks a configuration-over-PCIe capability through the register protocol it needs to load a device image. It reaches that capability through a simple 32-bit register master port. Each access holds a request until it is acknowledged, and only one access is outstanding at a time. A start pulse, together with three image flags (compressed, encrypted, partial), launches a session. The block then runs the setup steps and raises a "ready for data" level. An external streaming stage moves the image and answers with a "data finished" pulse. After that the block runs teardown and completion on its own.

The protocol is strictly ordered. Mode-control bits are set by separate read-modify-writes. Clock handover is done with bursts of zero writes to the data register. Status polls are bounded, with a fixed pause between reads. If a previous session was left open, the block closes it first. The block reports busy, a one-cycle done pulse and a 3-bit result code.

Top module: `pcie_cfg_loader`

## Requirements
- R1: A start with the partial flag set produces done in the next cycle with result code 1, and no register access is made.
- R2: Every session that is not rejected first reads status at 0x21C. If status bit 20 (enable) is 0, the session ends with result code 2 after that single access.
- R3: The final setup write to mode control (0x220) puts a ratio in bits [15:8] and keeps all other bits as read. The ratio is 8 when the compressed flag is set, 4 when only the encrypted flag is set, and 1 otherwise.
- R4: Mode-control bit 1 is set by one read-then-write. Bit 0 is set afterwards by a second, separate read-then-write. Each of these writes keeps all other bits as read.
- R5: A clock-handover burst reads mode control and writes it back with bits [15:8] equal to 1 and all other bits kept. It then makes exactly DUMMY_WRITES (default 244) writes of zero to the data register 0x228. A complete session has three bursts, and one with an open previous session has four.
- R6: Setup order: set program-control (0x22C) bit 0, poll for status bit 18 = 1, run a burst, set program-control bit 1, write the ratio, then assert stream_ready_o. No access is made while stream_ready_o is high.
- R7: If status bit 18 is 1 at the first read, a full teardown runs before the mode-control steps.
- R8: Teardown order: read program control. Write it back with bit 1 cleared. In a second write, also clear bit 0. Run a burst. Then poll for status bit 18 = 0.
- R9: Completion runs teardown and then reads 0x234. If bit 5 of that register is set, the session ends with result code 4. Otherwise mode-control bits 0 and 1 are cleared in one write, and status is polled until bits 21 and 24 are both 1.
- R10: A poll makes at most ceil(timeout/POLL_GAP_US) status reads: 1 read for the config-ready polls (10 us) and 200 reads for the final poll (2000 us). After each failing read it waits POLL_GAP_US*CYC_PER_US cycles. If every read fails, the session ends with result code 3.
- R11: A request holds its address, direction and data stable until acknowledged, and it is dropped in the cycle after the acknowledge.
- R12: busy_o is high from the cycle after an accepted start through the done cycle. done_o is a single-cycle pulse. A successful session gives result code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session start pulse, ignored while busy |
| img_compressed_i | input | 1 | Image is compressed |
| img_encrypted_i | input | 1 | Image is encrypted |
| img_partial_i | input | 1 | Partial reconfiguration requested (rejected) |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle end-of-session pulse |
| result_o | output | 3 | 0 ok, 1 partial rejected, 2 no device, 3 timeout, 4 latched config error |
| stream_ready_o | output | 1 | Setup complete, data streaming may run |
| stream_finished_i | input | 1 | Streaming stage has finished |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | AW | Byte address of the register |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access acknowledge |

## Verification
The bench's register model starts mode control with foreign bits and a non-zero ratio field in place. A design that wrote constants instead of modifying the value it read back would therefore break the ordered access comparison. Separate sessions leave a session open, hold config-ready low, never reach user mode, and report a latched error. A design with a wrong retry count, a missing teardown, or teardown writes merged into one would show up as extra, missing or reordered accesses, or as a wrong result code. The model counts zero writes to the data register and measures the gap between status reads, so an off-by-one burst length or a poll without its pause would be caught.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  localparam logic [11:0] ADDR_STAT = 12'h21C;
  localparam logic [11:0] ADDR_MODE = 12'h220;
  localparam logic [11:0] ADDR_DATA = 12'h228;
  localparam logic [11:0] ADDR_PROG = 12'h22C;
  localparam logic [11:0] ADDR_UERR = 12'h234;

  localparam int ST_READY  = 18;
  localparam int ST_EN     = 20;
  localparam int ST_USER   = 21;
  localparam int ST_PLDCLK = 24;
  localparam int MC_MODE   = 0;
  localparam int MC_CLKSEL = 1;
  localparam int MC_RATIO  = 8;
  localparam int PC_CONFIG = 0;
  localparam int PC_XFER   = 1;
  localparam int UE_CFG    = 5;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_PARTIAL = 3'd1,
    RES_NODEV   = 3'd2,
    RES_TIMEOUT = 3'd3,
    RES_CFGERR  = 3'd4
  } result_e;

  typedef enum logic [1:0] {RET_SETUP_A, RET_SETUP_B, RET_TEARDOWN} burst_ret_e;
  typedef enum logic [1:0] {PK_READY_HI, PK_READY_LO, PK_USER} poll_kind_e;
endpackage

// File: rtl/pcl_ratio.sv
module pcl_ratio #(
  parameter int RW = 8
) (
  input  logic          compressed_i,
  input  logic          encrypted_i,
  output logic [RW-1:0] ratio_o
);
  always_comb begin
    if (compressed_i)     ratio_o = RW'(8);
    else if (encrypted_i) ratio_o = RW'(4);
    else                  ratio_o = RW'(1);
  end
endmodule

// File: rtl/pcl_bus_port.sv
module pcl_bus_port #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic          cmd_we_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          cmd_done_o,
  output logic [DW-1:0] cmd_rdata_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i
);
  logic          req_q, we_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (req_q) begin
        if (bus_ack_i) begin
          req_q  <= 1'b0;
          done_q <= 1'b1;
          if (!we_q) rdata_q <= bus_rdata_i;  // keep last read for RMW
        end
      end else if (cmd_valid_i && !done_q) begin
        req_q   <= 1'b1;
        we_q    <= cmd_we_i;
        addr_q  <= cmd_addr_i;
        wdata_q <= cmd_wdata_i;
      end
    end
  end

  assign cmd_done_o  = done_q;
  assign cmd_rdata_o = rdata_q;
  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
endmodule

// File: rtl/pcl_poll_timer.sv
module pcl_poll_timer #(
  parameter int CYC_PER_US  = 250,
  parameter int POLL_GAP_US = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int GAP_CYC = CYC_PER_US * POLL_GAP_US;
  localparam int CW      = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(GAP_CYC - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/pcie_cfg_loader.sv
module pcie_cfg_loader
  import pcl_pkg::*;
#(
  parameter int AW           = 12,
  parameter int DW           = 32,
  parameter int CYC_PER_US   = 250,
  parameter int POLL_GAP_US  = 10,
  parameter int READY_TMO_US = 10,
  parameter int USER_TMO_US  = 2000,
  parameter int DUMMY_WRITES = 244
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          img_compressed_i,
  input  logic          img_encrypted_i,
  input  logic          img_partial_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    result_o,
  output logic          stream_ready_o,
  input  logic          stream_finished_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i
);
  localparam int RW          = 8;
  localparam int READY_TRIES = (READY_TMO_US + POLL_GAP_US - 1) / POLL_GAP_US;
  localparam int USER_TRIES  = (USER_TMO_US + POLL_GAP_US - 1) / POLL_GAP_US;
  localparam int MAX_TRIES   = (READY_TRIES > USER_TRIES) ? READY_TRIES : USER_TRIES;
  localparam int TRY_W       = $clog2(MAX_TRIES + 1);
  localparam int DCW         = $clog2(DUMMY_WRITES + 1);
  localparam logic [DW-1:0] RMASK = DW'({RW{1'b1}}) << MC_RATIO;
  localparam logic [DW-1:0] RONE  = DW'(1) << MC_RATIO;

  typedef enum logic [4:0] {
    S_IDLE, S_CHK_STAT, S_MODE_RD1, S_MODE_WR1, S_MODE_RD2, S_MODE_WR2,
    S_DM_RD, S_DM_WR, S_DM_DATA, S_PROG_RD1, S_PROG_WR1, S_PROG_RD2,
    S_PROG_WR2, S_RATIO_RD, S_RATIO_WR, S_STREAM, S_TD_RD, S_TD_WR1,
    S_TD_WR2, S_UERR_RD, S_CLR_RD, S_CLR_WR, S_POLL_RD, S_POLL_WAIT, S_END
  } state_e;

  state_e        state_q;
  burst_ret_e    bret_q;
  poll_kind_e    pkind_q;
  result_e       res_q;
  logic [TRY_W-1:0] tries_q;
  logic [DCW-1:0]   dcnt_q;
  logic [RW-1:0]    ratio_q, ratio_d;
  logic             td_setup_q;

  logic          cmd_valid, cmd_we, cmd_done;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata, rd;
  logic          poll_match, tmr_start, tmr_exp;

  pcl_ratio #(.RW(RW)) u_ratio (
    .compressed_i (img_compressed_i),
    .encrypted_i  (img_encrypted_i),
    .ratio_o      (ratio_d)
  );

  pcl_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid),
    .cmd_we_i    (cmd_we),
    .cmd_addr_i  (cmd_addr),
    .cmd_wdata_i (cmd_wdata),
    .cmd_done_o  (cmd_done),
    .cmd_rdata_o (rd),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ack_i   (bus_ack_i)
  );

  pcl_poll_timer #(.CYC_PER_US(CYC_PER_US), .POLL_GAP_US(POLL_GAP_US)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (tmr_start),
    .expired_o (tmr_exp)
  );

  // access issued by each state
  always_comb begin
    cmd_valid = 1'b1;
    cmd_we    = 1'b0;
    cmd_addr  = AW'(ADDR_STAT);
    cmd_wdata = '0;
    unique case (state_q)
      S_CHK_STAT, S_POLL_RD: cmd_addr = AW'(ADDR_STAT);
      S_MODE_RD1, S_MODE_RD2, S_DM_RD, S_RATIO_RD, S_CLR_RD: cmd_addr = AW'(ADDR_MODE);
      S_MODE_WR1: begin
        cmd_we = 1'b1; cmd_addr = AW'(ADDR_MODE);
        cmd_wdata = rd | (DW'(1) << MC_CLKSEL);
      end
      S_MODE_WR2: begin
        cmd_we = 1'b1; cmd_addr = AW'(ADDR_MODE);
        cmd_wdata = rd | (DW'(1) << MC_MODE);
      end
      S_DM_WR: begin
        cmd_we = 1'b1; cmd_addr = AW'(ADDR_MODE);
        cmd_wdata = (rd & ~RMASK) | RONE;
      end
      S_RATIO_WR: begin
        cmd_we = 1'b1; cmd_addr = AW'(ADDR_MODE);
        cmd_wdata = (rd & ~RMASK) | (DW'(ratio_q) << MC_RATIO);
      end
      S_CLR_WR: begin
        cmd_we = 1'b1; cmd_addr = AW'(ADDR_MODE);
        cmd_wdata = rd & ~((DW'(1) << MC_MODE) | (DW'(1) << MC_CLKSEL));
      end
      S_DM_DATA: begin
        cmd_we = 1'b1; cmd_addr = AW'(ADDR_DATA);
      end
      S_PROG_RD1, S_PROG_RD2, S_TD_RD: cmd_addr = AW'(ADDR_PROG);
      S_PROG_WR1: begin
        cmd_we = 1'b1; cmd_addr = AW'(ADDR_PROG);
        cmd_wdata = rd | (DW'(1) << PC_CONFIG);
      end
      S_PROG_WR2: begin
        cmd_we = 1'b1; cmd_addr = AW'(ADDR_PROG);
        cmd_wdata = rd | (DW'(1) << PC_XFER);
      end
      S_TD_WR1: begin
        cmd_we = 1'b1; cmd_addr = AW'(ADDR_PROG);
        cmd_wdata = rd & ~(DW'(1) << PC_XFER);
      end
      S_TD_WR2: begin
        cmd_we = 1'b1; cmd_addr = AW'(ADDR_PROG);
        cmd_wdata = rd & ~((DW'(1) << PC_XFER) | (DW'(1) << PC_CONFIG));
      end
      S_UERR_RD: cmd_addr = AW'(ADDR_UERR);
      default: cmd_valid = 1'b0;
    endcase
  end

  always_comb begin
    unique case (pkind_q)
      PK_READY_HI: poll_match = rd[ST_READY];
      PK_READY_LO: poll_match = !rd[ST_READY];
      default:     poll_match = rd[ST_USER] && rd[ST_PLDCLK];
    endcase
  end

  assign tmr_start = (state_q == S_POLL_RD) && cmd_done && !poll_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      bret_q     <= RET_SETUP_A;
      pkind_q    <= PK_READY_HI;
      res_q      <= RES_OK;
      tries_q    <= '0;
      dcnt_q     <= '0;
      ratio_q    <= '0;
      td_setup_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          if (img_partial_i) begin
            res_q   <= RES_PARTIAL;
            state_q <= S_END;
          end else begin
            res_q   <= RES_OK;
            ratio_q <= ratio_d;
            state_q <= S_CHK_STAT;
          end
        end
        S_CHK_STAT: if (cmd_done) begin
          if (!rd[ST_EN]) begin
            res_q   <= RES_NODEV;
            state_q <= S_END;
          end else if (rd[ST_READY]) begin
            td_setup_q <= 1'b1;
            state_q    <= S_TD_RD;
          end else state_q <= S_MODE_RD1;
        end
        S_MODE_RD1: if (cmd_done) state_q <= S_MODE_WR1;
        S_MODE_WR1: if (cmd_done) state_q <= S_MODE_RD2;
        S_MODE_RD2: if (cmd_done) state_q <= S_MODE_WR2;
        S_MODE_WR2: if (cmd_done) begin
          bret_q  <= RET_SETUP_A;
          state_q <= S_DM_RD;
        end
        S_DM_RD: if (cmd_done) state_q <= S_DM_WR;
        S_DM_WR: if (cmd_done) begin
          dcnt_q  <= '0;
          state_q <= S_DM_DATA;
        end
        S_DM_DATA: if (cmd_done) begin
          if (dcnt_q == DCW'(DUMMY_WRITES - 1)) begin
            unique case (bret_q)
              RET_SETUP_A: state_q <= S_PROG_RD1;
              RET_SETUP_B: state_q <= S_PROG_RD2;
              default: begin
                pkind_q <= PK_READY_LO;
                tries_q <= TRY_W'(READY_TRIES);
                state_q <= S_POLL_RD;
              end
            endcase
          end else dcnt_q <= dcnt_q + 1'b1;
        end
        S_PROG_RD1: if (cmd_done) state_q <= S_PROG_WR1;
        S_PROG_WR1: if (cmd_done) begin
          pkind_q <= PK_READY_HI;
          tries_q <= TRY_W'(READY_TRIES);
          state_q <= S_POLL_RD;
        end
        S_POLL_RD: if (cmd_done) begin
          if (poll_match) begin
            unique case (pkind_q)
              PK_READY_HI: begin
                bret_q  <= RET_SETUP_B;
                state_q <= S_DM_RD;
              end
              PK_READY_LO: state_q <= td_setup_q ? S_MODE_RD1 : S_UERR_RD;
              default:     state_q <= S_END;
            endcase
          end else begin
            tries_q <= tries_q - 1'b1;
            state_q <= S_POLL_WAIT;
          end
        end
        S_POLL_WAIT: if (tmr_exp) begin
          if (tries_q == '0) begin
            res_q   <= RES_TIMEOUT;
            state_q <= S_END;
          end else state_q <= S_POLL_RD;
        end
        S_PROG_RD2: if (cmd_done) state_q <= S_PROG_WR2;
        S_PROG_WR2: if (cmd_done) state_q <= S_RATIO_RD;
        S_RATIO_RD: if (cmd_done) state_q <= S_RATIO_WR;
        S_RATIO_WR: if (cmd_done) state_q <= S_STREAM;
        S_STREAM: if (stream_finished_i) begin
          td_setup_q <= 1'b0;
          state_q    <= S_TD_RD;
        end
        S_TD_RD:  if (cmd_done) state_q <= S_TD_WR1;
        S_TD_WR1: if (cmd_done) state_q <= S_TD_WR2;
        S_TD_WR2: if (cmd_done) begin
          bret_q  <= RET_TEARDOWN;
          state_q <= S_DM_RD;
        end
        S_UERR_RD: if (cmd_done) begin
          if (rd[UE_CFG]) begin
            res_q   <= RES_CFGERR;
            state_q <= S_END;
          end else state_q <= S_CLR_RD;
        end
        S_CLR_RD: if (cmd_done) state_q <= S_CLR_WR;
        S_CLR_WR: if (cmd_done) begin
          pkind_q <= PK_USER;
          tries_q <= TRY_W'(USER_TRIES);
          state_q <= S_POLL_RD;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o         = (state_q != S_IDLE);
  assign done_o         = (state_q == S_END);
  assign result_o       = res_q;
  assign stream_ready_o = (state_q == S_STREAM);
endmodule

// File: rtl/pcl_checker.sv
module pcl_checker
  import pcl_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          img_partial_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [2:0]    result_o,
  input logic          stream_ready_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_ack_i
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)
                                && $stable(bus_wdata_o)); // R11
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i |=> !bus_req_o); // R11
  AST_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && (bus_addr_o == AW'(ADDR_DATA)) |-> bus_we_o && (bus_wdata_o == '0)); // R5
  AST_PARTIAL_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && img_partial_i |=> done_o && (result_o == 3'd1) && !bus_req_o); // R1
  AST_STREAM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stream_ready_o |-> !bus_req_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R12
endmodule

bind pcie_cfg_loader pcl_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .img_partial_i  (img_partial_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .result_o       (result_o),
  .stream_ready_o (stream_ready_o),
  .bus_req_o      (bus_req_o),
  .bus_we_o       (bus_we_o),
  .bus_addr_o     (bus_addr_o),
  .bus_wdata_o    (bus_wdata_o),
  .bus_ack_i      (bus_ack_i)
);

// File: tb/pcie_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module pcie_cfg_loader_tb_top;
  localparam int GAP = 10;  // CYC_PER_US=1, 10 us pause
  localparam logic [31:0] MODE_INIT = 32'h00A5_37F0;
  localparam logic [11:0] A_STAT = 12'h21C, A_MODE = 12'h220, A_DATA = 12'h228,
                          A_PROG = 12'h22C, A_UERR = 12'h234;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, comp = 0, enc = 0, part = 0, fin = 0;
  logic busy, done, sready, req, we, ack = 0;
  logic [2:0]  res;
  logic [11:0] addr;
  logic [31:0] wdata, rdata = '0;

  pcie_cfg_loader #(.CYC_PER_US(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .img_compressed_i(comp), .img_encrypted_i(enc), .img_partial_i(part),
    .busy_o(busy), .done_o(done), .result_o(res),
    .stream_ready_o(sready), .stream_finished_i(fin),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_rdata_i(rdata), .bus_ack_i(ack)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // register model
  logic [31:0] m_mode, m_prog;
  bit m_en, m_stuck, m_uerr, m_uphase;
  int m_ufail, m_un, n_acc, n_dummy, last_stat;

  // expected access list
  logic [11:0] q_a[$];
  bit          q_w[$];
  logic [31:0] q_d[$];
  string       q_t[$];
  logic [31:0] e_mode, e_prog;

  task automatic e_acc(input logic [11:0] a, input bit w, input logic [31:0] d, input string t);
    q_a.push_back(a); q_w.push_back(w); q_d.push_back(d); q_t.push_back(t);
  endtask

  task automatic e_burst(input string t);
    e_acc(A_MODE, 0, 0, t);
    e_mode = (e_mode & ~32'h0000_FF00) | 32'h0000_0100;
    e_acc(A_MODE, 1, e_mode, t);
    for (int i = 0; i < 244; i++) e_acc(A_DATA, 1, 0, t);
  endtask

  task automatic e_teardown(input string t);
    e_acc(A_PROG, 0, 0, t);
    e_prog = e_prog & ~32'h2; e_acc(A_PROG, 1, e_prog, t);
    e_prog = e_prog & ~32'h1; e_acc(A_PROG, 1, e_prog, t);
    e_burst("R5");
    e_acc(A_STAT, 0, 0, t);
  endtask

  // bus responder: acknowledges at negedge, compares against the list
  initial forever begin
    @(negedge clk);
    if (req && !ack) begin
      n_acc++;
      if (q_a.size() == 0) begin
        chk(0, "R6", "unexpected access addr", longint'(addr), 0);
      end else begin
        string t;
        logic [11:0] ea; bit ew; logic [31:0] ed;
        ea = q_a.pop_front(); ew = q_w.pop_front(); ed = q_d.pop_front(); t = q_t.pop_front();
        chk(addr == ea, t, "access address", longint'(addr), longint'(ea));
        chk(we == ew, t, "access direction", longint'(we), longint'(ew));
        if (ew && we) chk(wdata == ed, t, "write data", longint'(wdata), longint'(ed));
      end
      if (we) begin
        case (addr)
          A_MODE: begin m_mode = wdata; if (wdata[1:0] == 2'b00) m_uphase = 1; end
          A_PROG: m_prog = wdata;
          A_DATA: n_dummy++;
          default: ;
        endcase
      end else begin
        case (addr)
          A_STAT: begin
            rdata = 32'h0040_0000;
            rdata[18] = m_prog[0] && !m_stuck;
            rdata[20] = m_en;
            if (m_uphase) begin
              m_un++;
              if (m_un > 1) chk(cyc - last_stat >= GAP, "R10", "poll read gap",
                                cyc - last_stat, GAP);
              last_stat = cyc;
              if (m_un > m_ufail) begin rdata[21] = 1; rdata[24] = 1; end
            end
          end
          A_MODE: rdata = m_mode;
          A_PROG: rdata = m_prog;
          A_UERR: rdata = 32'h0000_0008 | (32'(m_uerr) << 5);
          default: rdata = 32'hDEAD_BEEF;
        endcase
      end
      ack = 1;
    end else begin
      ack = 0;
    end
  end

  task automatic session(input bit c, input bit e, input bit p, input bit open_s,
                         input bit en, input bit stuck, input bit uerr, input int ufail,
                         input int exp_res, input int exp_user, input int exp_dummy,
                         input string tag);
    bit streamed;
    logic [31:0] ratio;
    m_mode = MODE_INIT; m_prog = open_s ? 32'h3 : 32'h0;
    m_en = en; m_stuck = stuck; m_uerr = uerr; m_ufail = ufail;
    m_uphase = 0; m_un = 0; n_acc = 0; n_dummy = 0; last_stat = 0;
    q_a.delete(); q_w.delete(); q_d.delete(); q_t.delete();
    e_mode = MODE_INIT; e_prog = m_prog;
    ratio = c ? 32'd8 : (e ? 32'd4 : 32'd1);
    if (!p) begin
      e_acc(A_STAT, 0, 0, "R2");
      if (en) begin
        if (open_s) e_teardown("R7");
        e_acc(A_MODE, 0, 0, "R4"); e_mode |= 32'h2; e_acc(A_MODE, 1, e_mode, "R4");
        e_acc(A_MODE, 0, 0, "R4"); e_mode |= 32'h1; e_acc(A_MODE, 1, e_mode, "R4");
        e_burst("R5");
        e_acc(A_PROG, 0, 0, "R6"); e_prog |= 32'h1; e_acc(A_PROG, 1, e_prog, "R6");
        e_acc(A_STAT, 0, 0, "R10");
        if (!stuck) begin
          e_burst("R6");
          e_acc(A_PROG, 0, 0, "R6"); e_prog |= 32'h2; e_acc(A_PROG, 1, e_prog, "R6");
          e_acc(A_MODE, 0, 0, "R3");
          e_mode = (e_mode & ~32'h0000_FF00) | (ratio << 8);
          e_acc(A_MODE, 1, e_mode, "R3");
          e_teardown("R8");
          e_acc(A_UERR, 0, 0, "R9");
          if (!uerr) begin
            e_acc(A_MODE, 0, 0, "R9"); e_mode &= ~32'h3; e_acc(A_MODE, 1, e_mode, "R9");
            for (int i = 0; i < exp_user; i++) e_acc(A_STAT, 0, 0, "R10");
          end
        end
      end
    end
    @(negedge clk);
    comp = c; enc = e; part = p; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R12", {tag, " busy after start"}, busy, 1);
    streamed = 0;
    while (!done) begin
      @(negedge clk);
      if (sready && !streamed) begin
        streamed = 1;
        for (int i = 0; i < 6; i++) begin
          chk(!req && sready, "R6", {tag, " quiet while streaming"}, req, 0);
          @(negedge clk);
        end
        fin = 1; @(negedge clk); fin = 0;
      end
    end
    chk(res == 3'(exp_res), tag, "result code", res, exp_res);
    chk(q_a.size() == 0, "R6", {tag, " accesses left unissued"}, q_a.size(), 0);
    chk(n_dummy == exp_dummy, "R5", {tag, " data register zero writes"}, n_dummy, exp_dummy);
    if (p) chk(n_acc == 0, "R1", {tag, " accesses"}, n_acc, 0);
    if (!en && !p) chk(n_acc == 1, "R2", {tag, " accesses"}, n_acc, 1);
    @(negedge clk);
    chk(!done && !busy, "R12", {tag, " done pulse ends"}, {done, busy}, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !req && !sready && res == 0, "R12", "reset state",
        {busy, done, req, sready, res}, 0);
    session(1, 0, 1, 0, 1, 0, 0, 0, 1, 0, 0,   "R1 partial");
    session(0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0,   "R2 no device");
    session(0, 0, 0, 0, 1, 0, 0, 2, 0, 3, 732, "R3 R6 R9 plain");
    session(1, 1, 0, 1, 1, 0, 0, 0, 0, 1, 976, "R7 R3 compressed open");
    session(0, 1, 0, 0, 1, 0, 1, 0, 4, 0, 732, "R9 R3 encrypted latched");
    session(0, 0, 0, 0, 1, 1, 0, 0, 3, 0, 244, "R10 ready stuck");
    session(0, 0, 0, 0, 1, 0, 0, 1000, 3, 200, 732, "R10 user timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc == 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule